// File: doc/BRIEF.md
# Cycle Counter with Control Register

This block is a performance-monitor cycle counter that sits behind a small synchronous register port. Software reaches two registers through a one-bit select. The control register turns counting on and off, picks either a count per clock or a count per 64 clocks, and carries a counter-clear request bit that is never stored. The count register is 32 bits wide. Software can read it at any time and can overwrite it at any time.

While counting is enabled, the count register goes up by one on every clock. When the divide bit is set, it goes up once every 64 clocks instead. While counting is disabled, the value stays frozen and a read returns that frozen value. A 6-bit prescale phase paces the divided mode. The phase restarts whenever the count is cleared or loaded, so the first divided increment after either event arrives 64 clocks later.

Reads are registered. A read strobe at a clock edge captures the selected register as it stood before that edge, and the captured word appears on the read-data port one cycle later. Between reads the read-data port keeps its last value.

Top module: `cycle_meter`

## Requirements
- R1: After a synchronous reset, the control register reads as the IMPL_CODE parameter in bits 31:24 with every other bit 0. The count register reads 0 and the read-data port is 0.
- R2: With control bit 0 (enable) set and control bit 3 (divide) clear, the count rises by exactly one on every clock edge. A control write that changes the mode takes effect from the following edge.
- R3: With control bit 0 clear, the count holds its value, and repeated reads return the same frozen value.
- R4: With control bits 0 and 3 both set, the count rises once every 64 clock edges. The first increment comes 64 edges after the last clear or load of the count.
- R5: A control write updates only bits 0, 3, 4 and 5 (mask 0x39). Every other control bit keeps its value.
- R6: A control write with bit 2 set clears the count to 0 and restarts the prescale phase. Bit 2 is not stored and always reads back as 0.
- R7: A write to the count register (select = 1) loads the written value directly, whether counting is enabled or not. It also restarts the prescale phase, and counting carries on from the loaded value.
- R8: The count wraps from 0xFFFFFFFF to 0x00000000 with no other effect.
- R9: A single control write that sets bit 2 while also changing bits 0 or 3 clears the count at that edge. The new mode then applies from the next edge.
- R10: A read strobe with select 0 (control) or select 1 (count) puts the selected register's pre-edge value on the read-data port after that edge. Without a read strobe the read-data port holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 control, 1 count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The hardest situations to reach from the ports are the edges of the divided mode. One is the exact edge where the 64-clock phase rolls over. Another is a clear or load landing partway through a phase, which must push the next increment back a full 64 clocks. A third is a clear and a mode change arriving in the same write. Directed sequences cover each of these: a combined clear-plus-mode write, reads placed just before and just after the 64th edge, and a count load a few steps short of 0xFFFFFFFF to force the wrap. Seeded random writes, reads and idle gaps of up to 70 clocks then leave loads and clears at arbitrary phase offsets. Every read is compared against a cycle-level reference model in the bench.

// File: rtl/cycle_meter_pkg.sv
package cycle_meter_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned CODE_W      = 8;
  localparam int unsigned BIT_ENABLE  = 0;
  localparam int unsigned BIT_CLEAR   = 2;
  localparam int unsigned BIT_DIVIDE  = 3;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0000_0039;
  localparam logic SEL_CTRL  = 1'b0;
  localparam logic SEL_COUNT = 1'b1;
endpackage

// File: rtl/cycle_meter_ctrl.sv
module cycle_meter_ctrl
  import cycle_meter_pkg::*;
#(
  parameter logic [CODE_W-1:0] IMPL_CODE = 8'h41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              run_en,
  output logic              div_en,
  output logic              clr_req
);
  localparam logic [DATA_W-1:0] RESET_VAL = {IMPL_CODE, {(DATA_W-CODE_W){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RESET_VAL;
    end else if (wr_ctrl) begin
      ctrl_q <= (ctrl_q & ~CTRL_WMASK) | (wdata & CTRL_WMASK);
    end
  end

  assign run_en  = ctrl_q[BIT_ENABLE];
  assign div_en  = ctrl_q[BIT_DIVIDE];
  assign clr_req = wr_ctrl & wdata[BIT_CLEAR];

  // R5
  ro_bits_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ctrl_q & ~CTRL_WMASK) == ($past(ctrl_q) & ~CTRL_WMASK)));

  // R6
  clr_not_stored_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (ctrl_q[BIT_CLEAR] == 1'b0));
endmodule

// File: rtl/cycle_meter_prescale.sv
module cycle_meter_prescale #(
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic div_en,
  input  logic restart,
  output logic tick
);
  localparam logic [DIV_LOG2-1:0] PH_LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] phase_q;
  logic                phase_run;

  assign phase_run = run_en & div_en;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (phase_run) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run_en & (~div_en | (phase_q == PH_LAST));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!phase_run && !restart) |=> $stable(phase_q));

  // R4
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/cycle_meter_count.sv
module cycle_meter_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr && !load) |=> $stable(cnt_q));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/cycle_meter.sv
module cycle_meter
  import cycle_meter_pkg::*;
#(
  parameter logic [CODE_W-1:0] IMPL_CODE = 8'h41,
  parameter int unsigned       DIV_LOG2  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cnt_q;
  logic              run_en, div_en, clr_req, tick;
  logic              wr_ctrl, wr_cnt, restart;

  assign wr_ctrl = wr_en & (reg_sel == SEL_CTRL);
  assign wr_cnt  = wr_en & (reg_sel == SEL_COUNT);
  assign restart = clr_req | wr_cnt;

  cycle_meter_ctrl #(.IMPL_CODE(IMPL_CODE)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wdata   (wdata),
    .ctrl_q  (ctrl_q),
    .run_en  (run_en),
    .div_en  (div_en),
    .clr_req (clr_req)
  );

  cycle_meter_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .div_en  (div_en),
    .restart (restart),
    .tick    (tick)
  );

  cycle_meter_count #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_req),
    .load     (wr_cnt),
    .load_val (wdata),
    .tick     (tick),
    .cnt_q    (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= (reg_sel == SEL_COUNT) ? cnt_q : ctrl_q;
    end
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !div_en && !clr_req && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 32'd1));

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !clr_req && !wr_cnt) |=> $stable(cnt_q));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (cnt_q == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/cycle_meter_tb.sv
module cycle_meter_tb;
  localparam logic [7:0] CODE = 8'h41;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cycle_meter #(.IMPL_CODE(CODE)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata)
  );

  // Reference model built from the requirements
  logic [31:0] m_ctrl, m_cnt, m_rd;
  logic [5:0]  m_ph;

  function automatic logic [31:0] masked_ctrl(logic [31:0] old, logic [31:0] v);
    return (old & ~32'h39) | (v & 32'h39);
  endfunction

  function automatic logic model_tick(logic [31:0] c, logic [5:0] ph);
    return c[0] && (!c[3] || ph == 6'd63);
  endfunction

  always @(posedge clk) begin
    logic [31:0] ncnt;
    logic [5:0]  nph;
    if (rst) begin
      m_ctrl = {CODE, 24'h0};
      m_cnt  = '0;
      m_ph   = '0;
      m_rd   = '0;
    end else begin
      nph  = (m_ctrl[0] && m_ctrl[3]) ? m_ph + 6'd1 : m_ph;
      ncnt = model_tick(m_ctrl, m_ph) ? m_cnt + 32'd1 : m_cnt;
      if (rd_en) m_rd = reg_sel ? m_cnt : m_ctrl;
      if (wr_en && !reg_sel) begin
        if (wdata[2]) begin ncnt = '0; nph = '0; end
        m_ctrl = masked_ctrl(m_ctrl, wdata);
      end
      if (wr_en && reg_sel) begin ncnt = wdata; nph = '0; end
      m_cnt = ncnt;
      m_ph  = nph;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic op(input logic w, input logic r, input logic s, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; reg_sel = s; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0; wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmp(input string req, input logic [31:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, rdata, exp);
    end
  endtask

  task automatic rd_model(input string req, input logic s);
    op(0, 1, s, '0);
    cmp(req, m_rd);
  endtask

  task automatic rd_lit(input string req, input logic s, input logic [31:0] exp);
    op(0, 1, s, '0);
    cmp(req, exp);
    cmp(req, m_rd);
  endtask

  initial begin
    logic [31:0] a;
    logic [31:0] frozen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    cmp("R1", 32'h0);
    rd_lit("R1", 0, {CODE, 24'h0});
    rd_lit("R1", 1, 32'h0);
    // R2 single-cycle counting
    op(1, 0, 0, 32'h1);
    rd_lit("R2", 1, 32'd1);
    rd_lit("R2", 1, 32'd3);
    // R3 freeze
    op(1, 0, 0, 32'h0);
    idle(10);
    op(0, 1, 1, '0);
    frozen = rdata;
    cmp("R3", m_rd);
    idle(7);
    rd_lit("R3", 1, frozen);
    // R5 R6 mask, clear, bit 2 not stored
    op(1, 0, 0, 32'hFFFF_FFFF);
    rd_lit("R5", 0, {CODE, 24'h39});
    rd_lit("R6", 1, 32'h0);
    // R4 divided mode: write at edge w, read at w+4 so far; ticks at w+64
    idle(57);
    rd_lit("R4", 1, 32'h0);
    idle(1);
    rd_lit("R4", 1, 32'h1);
    // R7 R8 load and wrap in single-cycle mode
    op(1, 0, 0, 32'h1);
    op(1, 0, 1, 32'hFFFF_FFFE);
    rd_lit("R7", 1, 32'hFFFF_FFFF);
    rd_lit("R8", 1, 32'h1);
    // R9 clear plus mode change in one write
    op(1, 0, 0, 32'h0000_000D);
    rd_lit("R9", 1, 32'h0);
    rd_lit("R9", 0, {CODE, 24'h09});
    // R7 load while disabled
    op(1, 0, 0, 32'h0);
    op(1, 0, 1, 32'h0000_1234);
    idle(5);
    rd_lit("R7", 1, 32'h0000_1234);
    // R10 hold without read strobe, and select
    op(1, 0, 0, 32'h1);
    rd_model("R10", 0);
    idle(9);
    cmp("R10", {CODE, 24'h01});
    rd_model("R10", 1);
    // Random mix
    for (int k = 0; k < 400; k++) begin
      a = $urandom;
      case ($urandom % 6)
        0: op(1, 0, 0, a);
        1: op(1, 0, 1, a);
        2: rd_model("R10", 0);
        3, 4: rd_model("R2", 1);
        default: idle($urandom % 71);
      endcase
    end
    rd_model("R4", 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule